// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a successive-approximation analog-to-digital converter. It runs in the CPU clock domain and derives a slower converter tick by dividing that clock by two or by four, as a speed input selects. A start request taken while the block is enabled and idle latches the requested input channel. The block then closes the sample switch for a fixed number of converter periods. After that it opens the switch and resolves the held voltage one bit per converter period, most significant bit first.

The block never sees the analog side. It presents a trial code to an external DAC and reads back a single comparator bit that reports whether the input is at or above the DAC level. When the last bit is decided, the code goes into a result register that is read as a high word and a low word, and an end-of-conversion flag is raised. Reading the high word clears the flag, and so does starting the next conversion.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After synchronous reset, busy_o, eoc_o and sample_o are 0, and trial_o, data_hi_o and data_lo_o are all zeros.
- R2: A start_i seen at a clock edge while en_i is 1 and busy_o is 0 is accepted at that edge. From the next cycle, busy_o is 1, sample_o is 1, ch_sel_o holds the ch_req_i value from the accepting edge, and trial_o holds only its most significant bit set.
- R3: sample_o stays 1 for exactly SAMPLE_CLKS converter periods after the accepting edge and then falls to 0 for the rest of the conversion.
- R4: One converter period is 2 clock cycles when fast_i is 1 and 4 clock cycles when fast_i is 0. The divider restarts at the accepting edge.
- R5: The search decides bits from the MSB down to the LSB, one per converter period. Each bit keeps its value 1 exactly when cmp_i is 1 while it is under trial. With an ideal comparator the result is the largest code c for which c·Vref ≤ Vin·(2^RES_W − 1). For an 8-bit instance, 3.5 V against 5 V gives B2h.
- R6: eoc_o rises and busy_o falls at the clock edge exactly (SAMPLE_CLKS + RES_W) converter periods after the accepting edge.
- R7: data_hi_o shows result bits [RES_W−1:LO_W], and data_lo_o shows result bits [LO_W−1:0]. The result holds until the next conversion completes.
- R8: eoc_o is cleared by an accepted start or by a one-cycle hi_rd_i pulse. If hi_rd_i falls in the completion cycle, the completion wins and eoc_o ends up 1.
- R9: While busy_o is 1, start_i is ignored: the channel, the timing and the result of the running conversion are unchanged.
- R10: While en_i is 0, start_i is ignored, busy_o stays 0 and sample_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Converter enable; when 0, the divider is held cleared and starts are refused |
| fast_i | input | 1 | 1: converter period of 2 clocks, 0: converter period of 4 clocks |
| start_i | input | 1 | Conversion request |
| ch_req_i | input | CH_W | Requested analog input number |
| cmp_i | input | 1 | Comparator: 1 when the held input is at or above the DAC level |
| hi_rd_i | input | 1 | High-word read strobe; clears the end flag |
| ch_sel_o | output | CH_W | Channel presented to the input multiplexer |
| sample_o | output | 1 | Sample switch control, 1 = closed |
| trial_o | output | RES_W | Trial code driven to the DAC |
| busy_o | output | 1 | Conversion in progress |
| eoc_o | output | 1 | End-of-conversion flag |
| data_hi_o | output | RES_W-LO_W | Upper result bits |
| data_lo_o | output | LO_W | Lower result bits |

## Verification
Completion of the last bit decision, which sets the end flag, can land in the same cycle as a high-word read, which clears it. The bench raises hi_rd_i during exactly the cycle that ends with the final converter tick, and it expects the flag to read 1 afterwards with the new result in place. A start request that arrives partway through a running conversion also competes with it. That request carries a different channel, and the bench judges it ignored when the channel output, the completion edge and the result all still match the original request. Around these directed cases, random channel voltages, random speed settings and random read timings are checked against an ideal quantisation computed in the bench.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_SEARCH = 2'd2
    } sar_state_e;

    localparam int unsigned DIV_CNT_W = 2;

    // terminal count of the divider: period = limit + 1 clocks
    function automatic logic [DIV_CNT_W-1:0] div_limit(input logic fast);
        return fast ? DIV_CNT_W'(1) : DIV_CNT_W'(3);
    endfunction

endpackage

// File: rtl/sar_clkdiv.sv
module sar_clkdiv
    import sar_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic fast,
    input  logic clr,
    output logic tick
);

    logic [DIV_CNT_W-1:0] cnt_q;
    logic [DIV_CNT_W-1:0] lim;

    assign lim  = div_limit(fast);
    assign tick = en && (cnt_q >= lim);

    always_ff @(posedge clk) begin
        if (rst || !en || clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R4: a tick never lasts two clocks, so the period is at least two
    p_tick_gap_r4: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/sar_search.sv
module sar_search
    import sar_pkg::*;
#(
    parameter int unsigned RES_W       = 10,
    parameter int unsigned SAMPLE_CLKS = 3,
    parameter int unsigned CH_W        = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             start,
    input  logic [CH_W-1:0]  ch_req,
    input  logic             tick,
    input  logic             cmp,
    output logic             accept,
    output logic             busy,
    output logic             sample,
    output logic [CH_W-1:0]  ch_sel,
    output logic [RES_W-1:0] trial,
    output logic             done,
    output logic [RES_W-1:0] code
);

    localparam int unsigned IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1;
    localparam int unsigned SMP_W = $clog2(SAMPLE_CLKS + 1);
    localparam logic [RES_W-1:0] MSB_ONLY = {1'b1, {(RES_W-1){1'b0}}};

    sar_state_e        state_q;
    logic [IDX_W-1:0]  idx_q;
    logic [SMP_W-1:0]  smp_q;
    logic [RES_W-1:0]  next_trial;

    assign accept = start && en && (state_q == ST_IDLE);
    assign busy   = (state_q != ST_IDLE);
    assign sample = (state_q == ST_SAMPLE) && en;
    assign done   = (state_q == ST_SEARCH) && tick && (idx_q == '0);
    assign code   = next_trial;

    // decide the bit under trial, then raise the one below it
    always_comb begin
        next_trial        = trial;
        next_trial[idx_q] = cmp;
        if (idx_q != '0) begin
            next_trial[IDX_W'(idx_q - 1'b1)] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            smp_q   <= '0;
            ch_sel  <= '0;
            trial   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q <= ST_SAMPLE;
                        smp_q   <= '0;
                        ch_sel  <= ch_req;
                        trial   <= MSB_ONLY;
                        idx_q   <= IDX_W'(RES_W - 1);
                    end
                end
                ST_SAMPLE: begin
                    if (tick) begin
                        if (smp_q == SMP_W'(SAMPLE_CLKS - 1)) begin
                            state_q <= ST_SEARCH;
                            idx_q   <= IDX_W'(RES_W - 1);
                        end else begin
                            smp_q <= smp_q + 1'b1;
                        end
                    end
                end
                ST_SEARCH: begin
                    if (tick) begin
                        trial <= next_trial;
                        if (idx_q == '0) begin
                            state_q <= ST_IDLE;
                        end else begin
                            idx_q <= idx_q - 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R2: a fresh conversion presents half scale first
    p_msb_first_r2: assert property (@(posedge clk) disable iff (rst)
        accept |=> (trial == MSB_ONLY) && busy);

    // R3: the switch is only ever closed inside a conversion
    p_sample_in_busy_r3: assert property (@(posedge clk) disable iff (rst)
        sample |-> busy);

    // R9: a request during a conversion leaves the channel alone
    p_ch_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(ch_sel));

    // R6: the last decision returns the sequencer to idle
    p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

endmodule

// File: rtl/sar_result.sv
module sar_result #(
    parameter int unsigned RES_W = 10,
    parameter int unsigned LO_W  = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  done,
    input  logic [RES_W-1:0]      code,
    input  logic                  accept,
    input  logic                  hi_rd,
    output logic                  eoc,
    output logic [RES_W-LO_W-1:0] data_hi,
    output logic [LO_W-1:0]       data_lo
);

    logic [RES_W-1:0] res_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            eoc   <= 1'b0;
        end else begin
            if (done) begin
                res_q <= code;
            end
            // completion outranks a coincident clear
            if (done) begin
                eoc <= 1'b1;
            end else if (accept || hi_rd) begin
                eoc <= 1'b0;
            end
        end
    end

    assign data_hi = res_q[RES_W-1:LO_W];
    assign data_lo = res_q[LO_W-1:0];

    // R8: completion sets the flag even against a read
    p_eoc_priority_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> eoc);

    // R8: a read outside completion clears the flag
    p_eoc_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (hi_rd && !done) |=> !eoc);

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
    import sar_pkg::*;
#(
    parameter int unsigned RES_W       = 10,
    parameter int unsigned LO_W        = 2,
    parameter int unsigned SAMPLE_CLKS = 3,
    parameter int unsigned CH_W        = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  en_i,
    input  logic                  fast_i,
    input  logic                  start_i,
    input  logic [CH_W-1:0]       ch_req_i,
    input  logic                  cmp_i,
    input  logic                  hi_rd_i,
    output logic [CH_W-1:0]       ch_sel_o,
    output logic                  sample_o,
    output logic [RES_W-1:0]      trial_o,
    output logic                  busy_o,
    output logic                  eoc_o,
    output logic [RES_W-LO_W-1:0] data_hi_o,
    output logic [LO_W-1:0]       data_lo_o
);

    logic             tick;
    logic             accept;
    logic             done;
    logic [RES_W-1:0] code;

    sar_clkdiv u_div (
        .clk  (clk),
        .rst  (rst),
        .en   (en_i),
        .fast (fast_i),
        .clr  (accept),
        .tick (tick)
    );

    sar_search #(
        .RES_W       (RES_W),
        .SAMPLE_CLKS (SAMPLE_CLKS),
        .CH_W        (CH_W)
    ) u_seq (
        .clk    (clk),
        .rst    (rst),
        .en     (en_i),
        .start  (start_i),
        .ch_req (ch_req_i),
        .tick   (tick),
        .cmp    (cmp_i),
        .accept (accept),
        .busy   (busy_o),
        .sample (sample_o),
        .ch_sel (ch_sel_o),
        .trial  (trial_o),
        .done   (done),
        .code   (code)
    );

    sar_result #(
        .RES_W (RES_W),
        .LO_W  (LO_W)
    ) u_res (
        .clk     (clk),
        .rst     (rst),
        .done    (done),
        .code    (code),
        .accept  (accept),
        .hi_rd   (hi_rd_i),
        .eoc     (eoc_o),
        .data_hi (data_hi_o),
        .data_lo (data_lo_o)
    );

    // R10: a disabled, idle converter stays idle
    p_off_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (!en_i && !busy_o) |=> !busy_o);

    // R6: leaving a conversion always leaves the flag raised
    p_end_flag_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> eoc_o);

endmodule

// File: tb/sar_conv_ctrl_tb_top.sv
module sar_conv_ctrl_tb_top;

    localparam int N    = 10;
    localparam int N8   = 8;
    localparam int S    = 3;
    localparam int LO   = 2;
    localparam int CHW  = 3;
    localparam int VREF = 5000;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst, en, fast, start, start8, hi_rd;
    logic [CHW-1:0] ch_req;
    logic cmp, cmp8;

    logic [CHW-1:0]  ch_sel, ch_sel8;
    logic            sample, sample8, busy, busy8, eoc, eoc8;
    logic [N-1:0]    trial;
    logic [N8-1:0]   trial8;
    logic [N-LO-1:0] dhi;
    logic [LO-1:0]   dlo;
    logic [N8-LO-1:0] dhi8;
    logic [LO-1:0]   dlo8;

    int vin_ch [8];
    int vin8;
    int checks = 0;
    int fails  = 0;

    function automatic logic cmp_model(input int vin, input int c, input int nb);
        return (vin * ((1 << nb) - 1)) >= (c * VREF);
    endfunction

    function automatic int exp_code(input int vin, input int nb);
        int full = (1 << nb) - 1;
        int c = (vin * full) / VREF;
        if (c > full) c = full;
        return c;
    endfunction

    always_comb cmp  = cmp_model(vin_ch[ch_sel], int'(trial), N);
    always_comb cmp8 = cmp_model(vin8, int'(trial8), N8);

    sar_conv_ctrl #(.RES_W(N), .LO_W(LO), .SAMPLE_CLKS(S), .CH_W(CHW)) dut_i (
        .clk(clk), .rst(rst), .en_i(en), .fast_i(fast), .start_i(start),
        .ch_req_i(ch_req), .cmp_i(cmp), .hi_rd_i(hi_rd),
        .ch_sel_o(ch_sel), .sample_o(sample), .trial_o(trial), .busy_o(busy),
        .eoc_o(eoc), .data_hi_o(dhi), .data_lo_o(dlo)
    );

    sar_conv_ctrl #(.RES_W(N8), .LO_W(LO), .SAMPLE_CLKS(S), .CH_W(CHW)) dut8_i (
        .clk(clk), .rst(rst), .en_i(en), .fast_i(fast), .start_i(start8),
        .ch_req_i(ch_req), .cmp_i(cmp8), .hi_rd_i(1'b0),
        .ch_sel_o(ch_sel8), .sample_o(sample8), .trial_o(trial8), .busy_o(busy8),
        .eoc_o(eoc8), .data_hi_o(dhi8), .data_lo_o(dlo8)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    task automatic run_conv(input int ch, input bit fst, input bit rd_end, input bit dup);
        int dd = fst ? 2 : 4;
        int t  = (S + N) * dd;
        int ex = exp_code(vin_ch[ch], N);
        @(negedge clk);
        fast = fst; ch_req = CHW'(ch); start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk("R2 busy after accept", int'(busy), 1);
        chk("R2 channel latched", int'(ch_sel), ch);
        chk("R2 trial msb only", int'(trial), 1 << (N - 1));
        chk("R3 switch closed", int'(sample), 1);
        chk("R8 start clears eoc", int'(eoc), 0);
        for (int k = 1; k < t; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (k == S * dd - 1) chk("R3 R4 sample still closed", int'(sample), 1);
            if (k == S * dd)     chk("R3 R4 sample opened", int'(sample), 0);
            if (dup && k == 5) begin start = 1'b1; ch_req = CHW'(ch ^ 1); end
            if (dup && k == 6) begin
                start = 1'b0;
                chk("R9 channel unchanged", int'(ch_sel), ch);
            end
            if (k == t - 1) begin
                chk("R6 eoc not yet", int'(eoc), 0);
                chk("R6 busy before end", int'(busy), 1);
                if (rd_end) hi_rd = 1'b1;
            end
        end
        @(posedge clk);
        @(negedge clk);
        hi_rd = 1'b0;
        chk(rd_end ? "R8 completion beats read" : "R6 eoc at end", int'(eoc), 1);
        chk("R6 busy cleared", int'(busy), 0);
        chk(dup ? "R9 R5 result of first request" : "R5 result", int'({dhi, dlo}), ex);
        chk("R7 high word", int'(dhi), ex >> LO);
        chk("R7 low word", int'(dlo), ex & ((1 << LO) - 1));
    endtask

    task automatic read_hi();
        int ex = int'({dhi, dlo});
        @(negedge clk);
        hi_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        hi_rd = 1'b0;
        chk("R8 read clears eoc", int'(eoc), 0);
        chk("R7 data held after read", int'({dhi, dlo}), ex);
    endtask

    initial begin
        #600000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; en = 1'b1; fast = 1'b1; start = 1'b0; start8 = 1'b0;
        hi_rd = 1'b0; ch_req = '0; vin8 = 3500;
        for (int i = 0; i < 8; i++) vin_ch[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1
        chk("R1 busy", int'(busy), 0);
        chk("R1 eoc", int'(eoc), 0);
        chk("R1 sample", int'(sample), 0);
        chk("R1 trial", int'(trial), 0);
        chk("R1 data", int'({dhi, dlo}), 0);

        // directed: endpoints
        vin_ch[2] = 0;    run_conv(2, 1'b1, 1'b0, 1'b0);
        vin_ch[5] = 5000; run_conv(5, 1'b0, 1'b0, 1'b0);
        read_hi();
        vin_ch[1] = 4;    run_conv(1, 1'b1, 1'b0, 1'b0);
        vin_ch[7] = 5;    run_conv(7, 1'b0, 1'b1, 1'b0);
        vin_ch[3] = 2600; vin_ch[2] = 900; run_conv(3, 1'b1, 1'b0, 1'b1);

        // R10: disabled converter refuses a start
        @(negedge clk);
        en = 1'b0; start = 1'b1;
        for (int k = 0; k < 8; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (k == 7) begin
                chk("R10 busy stays low", int'(busy), 0);
                chk("R10 switch stays open", int'(sample), 0);
                chk("R10 eoc untouched", int'(eoc), 1);
            end
        end
        start = 1'b0; en = 1'b1;

        // R5: 8-bit instance, 3.5 V on 5 V gives B2h
        @(negedge clk);
        fast = 1'b1; start8 = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start8 = 1'b0;
        repeat ((S + N8) * 2) @(posedge clk);
        @(negedge clk);
        chk("R5 8-bit 3.5V code B2h", int'({dhi8, dlo8}), 'hB2);
        chk("R6 8-bit eoc", int'(eoc8), 1);

        // random mix
        for (int i = 0; i < 36; i++) begin
            int ch;
            for (int c = 0; c < 8; c++) vin_ch[c] = int'($urandom_range(0, VREF));
            ch = int'($urandom_range(0, 7));
            run_conv(ch, 1'($urandom_range(0, 1)), (i % 5) == 2, (i % 4) == 1);
            if ((i % 3) == 0) read_hi();
        end
        summary();
    end

endmodule